// File: doc/BRIEF.md
# I2C Master SCL Clock Generator

This block produces the serial clock for an I2C master. It drives the SCL wire in open-drain fashion: it either pulls the line low or lets it go. It also reads the real level of the wire back. The low phase and the high phase each last a programmable number of system clock cycles. Both counts come from one 16-bit configuration word: the high count sits in the upper byte and the low count in the lower byte. A setting below the safe minimum is raised to that minimum without any error being flagged.

After the block releases SCL, the high-phase count waits until the wire is actually seen high. A slave that keeps SCL low therefore lengthens the low phase without shortening the high phase that follows. Three single-cycle strobes mark points in each period for the byte engine that shifts SDA:
- the rising edge of SCL;
- the middle of the high phase, where SDA is sampled;
- the falling edge of SCL.

Configuration is captured only at phase boundaries, so the byte engine can rewrite the word at any time without producing a malformed phase. When the enable is low, SCL is released and the phase logic is held idle.

Top module: `scl_clkgen`

## Requirements
- R1: With high setting H (bits 15:8 of `clk_cfg`, bit 15 the MSB) at 2 or more, each high phase lasts exactly H+1 cycles, counted from the first cycle in which `scl_line` is sensed high.
- R2: With low setting L (bits 7:0 of `clk_cfg`, bit 7 the MSB) at 4 or more, SCL is driven low (`scl_pull_low` = 1) for exactly L+1 consecutive cycles in each low phase.
- R3: A high setting of 0 or 1 behaves as 2, giving 3 high cycles. A low setting of 0 to 3 behaves as 4, giving 5 low cycles.
- R4: If `scl_line` stays low after the block releases SCL, high-phase counting starts only in the first cycle the line is sensed high. The stretched period adds exactly the held cycles to the low time and leaves the high length unchanged.
- R5: The high setting is captured as the block enters a high phase, and the low setting is captured as it enters a low phase. A change to `clk_cfg` in the middle of a phase first affects the next phase of that kind.
- R6: `rise_stb` is high for exactly one cycle per high phase: the first cycle in which `scl_line` is high after release.
- R7: `mid_stb` is high for exactly one cycle per high phase, at zero-based high-cycle index floor(Heff/2). Heff is the effective high setting after the minimum is applied.
- R8: `fall_stb` is high in the first cycle of every low phase, that is, in every cycle where `scl_pull_low` has just risen.
- R9: One cycle after `en` is sampled low, SCL is released and no strobe fires. One cycle after `en` is sampled high from idle, a full low phase begins.
- R10: While reset is asserted and after it, before `en` is raised, SCL is released and all strobes are low.
- R11: At most one of the three strobes is high in any cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| en | input | 1 | Run the SCL generator; low releases SCL and idles the phase logic |
| clk_cfg | input | 16 | High setting in bits 15:8, low setting in bits 7:0 |
| scl_line | input | 1 | Sensed level of the SCL wire |
| scl_pull_low | output | 1 | 1 pulls SCL low; 0 releases it |
| rise_stb | output | 1 | One-cycle strobe on the first sensed-high cycle |
| mid_stb | output | 1 | One-cycle strobe in the middle of the high phase |
| fall_stb | output | 1 | One-cycle strobe on the first driven-low cycle |

## Verification
The hardest behaviours to reach from the ports are these:
- a slave stretching the clock;
- a configuration rewrite landing in the middle of a phase;
- `en` being dropped while a phase is running.

Each of these needs an action timed to a specific cycle inside a period. The bench models the wire as the AND of the block's release and an external hold signal. It then steps through each period one cycle at a time, so it knows at every point which phase it is in. From there it does three things:
- it raises the hold when a low phase starts and drops it just after a chosen clock edge, so the stretch has an exact length;
- it rewrites `clk_cfg` at the first cycle of a phase;
- it drops `en` a few cycles into a high or a low phase.

A sweep of every high and low setting from 0 to 9, plus the largest settings, covers the minimums and the mid-strobe position.

// File: rtl/scl_gen_pkg.sv
// Package: shared phase encoding and default limits for the SCL generator.
// Assumes: limits are unsigned system-clock counts minus one.
package scl_gen_pkg;

    typedef enum logic [1:0] {
        PH_IDLE = 2'd0,
        PH_LOW  = 2'd1,
        PH_HIGH = 2'd2
    } scl_phase_e;

    localparam int DEF_MIN_HIGH = 2;
    localparam int DEF_MIN_LOW  = 4;

endpackage

// File: rtl/scl_limit_reg.sv
// Module: clamps a raw phase setting to its minimum and holds it for a phase.
// Assumes: load is a single-cycle pulse coinciding with entry into the phase.
module scl_limit_reg #(
    parameter int W     = 8,
    parameter int MIN_V = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic [W-1:0] raw,
    output logic [W-1:0] lim
);
    localparam logic [W-1:0] MIN_L = W'(MIN_V);

    logic [W-1:0] clamped;

    // Raise settings below the minimum to the minimum.
    always_comb begin
        clamped = (raw < MIN_L) ? MIN_L : raw;
    end

    // Capture the clamped setting at the phase boundary; reset to the minimum.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            lim <= MIN_L;
        end else if (load) begin
            lim <= clamped;
        end
    end
endmodule

// File: rtl/scl_phase_cnt.sv
// Module: phase cycle counter with clear priority over advance.
// Assumes: the count never has to exceed the largest limit, so there is no wrap logic.
module scl_phase_cnt #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clr,
    input  logic         adv,
    output logic [W-1:0] cnt
);
    // Count cycles within a phase; restart from zero at every boundary.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (clr) begin
            cnt <= '0;
        end else if (adv) begin
            cnt <= cnt + 1'b1;
        end
    end
endmodule

// File: rtl/scl_phase_fsm.sv
// Module: sequences idle/low/high phases and issues load, clear and advance controls.
// Assumes: scl_line is already synchronous to clk; the high phase counts only
//          while the line is sensed high, which gives clock stretching.
module scl_phase_fsm
    import scl_gen_pkg::*;
#(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         en,
    input  logic         scl_line,
    input  logic [W-1:0] cnt,
    input  logic [W-1:0] hi_lim,
    input  logic [W-1:0] lo_lim,
    output scl_phase_e   phase,
    output logic         load_hi,
    output logic         load_lo,
    output logic         cnt_clr,
    output logic         cnt_adv
);
    scl_phase_e phase_nxt;

    // Choose the next phase from the enable, the count and the sensed line.
    always_comb begin
        phase_nxt = phase;
        unique case (phase)
            PH_IDLE: if (en) phase_nxt = PH_LOW;
            PH_LOW: begin
                if (!en)                  phase_nxt = PH_IDLE;
                else if (cnt == lo_lim)   phase_nxt = PH_HIGH;
            end
            PH_HIGH: begin
                if (!en)                              phase_nxt = PH_IDLE;
                else if (scl_line && cnt == hi_lim)   phase_nxt = PH_LOW;
            end
            default: phase_nxt = PH_IDLE;
        endcase
    end

    // Derive the boundary controls for the limit registers and the counter.
    always_comb begin
        load_lo = (phase_nxt == PH_LOW)  && (phase != PH_LOW);
        load_hi = (phase_nxt == PH_HIGH) && (phase != PH_HIGH);
        cnt_clr = (phase_nxt != phase) || (phase == PH_IDLE);
        cnt_adv = (phase == PH_LOW) || ((phase == PH_HIGH) && scl_line);
    end

    // Phase register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase <= PH_IDLE;
        end else begin
            phase <= phase_nxt;
        end
    end
endmodule

// File: rtl/scl_strobe_gen.sv
// Module: decodes the phase and count into rise, mid-high and fall strobes.
// Assumes: the high limit is at least 2, so the mid point never coincides
//          with the first high cycle.
module scl_strobe_gen
    import scl_gen_pkg::*;
#(
    parameter int W = 8
) (
    input  scl_phase_e   phase,
    input  logic         scl_line,
    input  logic [W-1:0] cnt,
    input  logic [W-1:0] hi_lim,
    output logic         rise_stb,
    output logic         mid_stb,
    output logic         fall_stb
);
    logic [W-1:0] mid_pt;
    logic         high_seen;

    // Decode the strobe positions within the current phase.
    always_comb begin
        mid_pt    = hi_lim >> 1;
        high_seen = (phase == PH_HIGH) && scl_line;
        rise_stb  = high_seen && (cnt == '0);
        mid_stb   = high_seen && (cnt == mid_pt);
        fall_stb  = (phase == PH_LOW) && (cnt == '0);
    end
endmodule

// File: rtl/scl_clkgen.sv
// Module: top of the I2C master SCL generator with open-drain drive and sensing.
// Assumes: clk_cfg holds the high setting in the upper half and the low setting
//          in the lower half; scl_line is synchronised before it reaches this block.
module scl_clkgen
    import scl_gen_pkg::*;
#(
    parameter int SET_W    = 8,
    parameter int MIN_HIGH = DEF_MIN_HIGH,
    parameter int MIN_LOW  = DEF_MIN_LOW
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               en,
    input  logic [2*SET_W-1:0] clk_cfg,
    input  logic               scl_line,
    output logic               scl_pull_low,
    output logic               rise_stb,
    output logic               mid_stb,
    output logic               fall_stb
);
    localparam int NFIELD = 2;
    localparam int F_LOW  = 0;
    localparam int F_HIGH = 1;

    scl_phase_e       phase;
    logic [SET_W-1:0] cnt;
    logic [SET_W-1:0] lim  [NFIELD];
    logic             load [NFIELD];
    logic             cnt_clr;
    logic             cnt_adv;
    logic             load_hi;
    logic             load_lo;

    // Map the FSM load pulses onto the per-field limit registers.
    always_comb begin
        load[F_LOW]  = load_lo;
        load[F_HIGH] = load_hi;
    end

    for (genvar g = 0; g < NFIELD; g++) begin : g_lim
        localparam int MIN_G = (g == F_HIGH) ? MIN_HIGH : MIN_LOW;
        scl_limit_reg #(
            .W     (SET_W),
            .MIN_V (MIN_G)
        ) u_lim (
            .clk   (clk),
            .rst_n (rst_n),
            .load  (load[g]),
            .raw   (clk_cfg[g*SET_W +: SET_W]),
            .lim   (lim[g])
        );
    end

    scl_phase_cnt #(.W(SET_W)) u_cnt (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (cnt_clr),
        .adv   (cnt_adv),
        .cnt   (cnt)
    );

    scl_phase_fsm #(.W(SET_W)) u_fsm (
        .clk      (clk),
        .rst_n    (rst_n),
        .en       (en),
        .scl_line (scl_line),
        .cnt      (cnt),
        .hi_lim   (lim[F_HIGH]),
        .lo_lim   (lim[F_LOW]),
        .phase    (phase),
        .load_hi  (load_hi),
        .load_lo  (load_lo),
        .cnt_clr  (cnt_clr),
        .cnt_adv  (cnt_adv)
    );

    scl_strobe_gen #(.W(SET_W)) u_stb (
        .phase    (phase),
        .scl_line (scl_line),
        .cnt      (cnt),
        .hi_lim   (lim[F_HIGH]),
        .rise_stb (rise_stb),
        .mid_stb  (mid_stb),
        .fall_stb (fall_stb)
    );

    // Open-drain drive: pull low only during the low phase, straight from the phase register.
    always_comb begin
        scl_pull_low = (phase == PH_LOW);
    end
endmodule

// File: rtl/scl_clkgen_chk.sv
// Module: assertion checker for scl_clkgen, attached with bind.
// Assumes: the same clock and reset as the block; it watches ports only.
module scl_clkgen_chk #(
    parameter int SET_W = 8
) (
    input logic clk,
    input logic rst_n,
    input logic en,
    input logic scl_line,
    input logic scl_pull_low,
    input logic rise_stb,
    input logic mid_stb,
    input logic fall_stb
);
    localparam int MAX_LOW = 1 << SET_W;

    logic [SET_W+1:0] low_run;

    // Length of the current run of driven-low cycles.
    always_ff @(posedge clk) begin
        if (!rst_n || !scl_pull_low) begin
            low_run <= '0;
        end else begin
            low_run <= low_run + 1'b1;
        end
    end

    // R10
    reset_release_chk: assert property (@(posedge clk) !rst_n |=> !scl_pull_low);

    // R9
    off_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !en |=> !scl_pull_low);

    // R9
    off_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !en |=> !(rise_stb || mid_stb || fall_stb));

    // R11
    one_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({rise_stb, mid_stb, fall_stb}));

    // R6
    rise_on_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rise_stb |-> (scl_line && !scl_pull_low));

    // R7
    mid_on_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mid_stb |-> (scl_line && !scl_pull_low));

    // R8
    fall_at_drive_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(scl_pull_low) |-> fall_stb);

    // R8
    fall_while_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        fall_stb |-> scl_pull_low);

    // R2
    low_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        low_run <= (SET_W + 2)'(MAX_LOW));
endmodule

bind scl_clkgen scl_clkgen_chk #(.SET_W(SET_W)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .en           (en),
    .scl_line     (scl_line),
    .scl_pull_low (scl_pull_low),
    .rise_stb     (rise_stb),
    .mid_stb      (mid_stb),
    .fall_stb     (fall_stb)
);

// File: tb/tb_scl_clkgen.sv
module tb_scl_clkgen;
    logic        clk = 1'b0;
    logic        rst_n;
    logic        en;
    logic [15:0] clk_cfg;
    logic        hold;
    logic        scl_pull_low, rise_stb, mid_stb, fall_stb;
    wire         scl_line = ~(scl_pull_low | hold);

    int nchk  = 0;
    int nfail = 0;

    always #10 clk = ~clk;

    scl_clkgen dut (
        .clk          (clk),
        .rst_n        (rst_n),
        .en           (en),
        .clk_cfg      (clk_cfg),
        .scl_line     (scl_line),
        .scl_pull_low (scl_pull_low),
        .rise_stb     (rise_stb),
        .mid_stb      (mid_stb),
        .fall_stb     (fall_stb)
    );

    function automatic int eff_h(input int raw);
        return (raw < 2) ? 2 : raw;
    endfunction

    function automatic int eff_l(input int raw);
        return (raw < 4) ? 4 : raw;
    endfunction

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        nchk++;
        if (!ok) begin
            nfail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    // Entered at the negedge of the first driven-low cycle; leaves at the first high one.
    task automatic run_low(input int raw, input int k, input bit chg,
                           input logic [15:0] nc, input string tag);
        int exp = eff_l(raw) + 1 + k;
        int l = 0;
        chk(fall_stb == 1'b1, "R8", int'(fall_stb), 1);
        if (k > 0) hold = 1'b1;
        if (chg) clk_cfg = nc;
        while (scl_line == 1'b0 && l < 700) begin
            l++;
            if (k > 0 && l == exp) begin
                @(posedge clk);
                #1 hold = 1'b0;
            end
            @(negedge clk);
        end
        chk(l == exp, tag, l, exp);
    endtask

    // Entered at the negedge of the first sensed-high cycle; leaves at the first low one.
    task automatic run_high(input int raw, input bit chg, input logic [15:0] nc,
                            input string tag);
        int eh = eff_h(raw);
        int h = 0, mid_at = -1, nmid = 0, nrise = 0;
        chk(rise_stb == 1'b1, "R6", int'(rise_stb), 1);
        if (chg) clk_cfg = nc;
        while (scl_line == 1'b1 && h < 700) begin
            if (mid_stb) begin
                nmid++;
                if (mid_at < 0) mid_at = h;
            end
            if (rise_stb) nrise++;
            h++;
            @(negedge clk);
        end
        chk(h == eh + 1, tag, h, eh + 1);
        chk(mid_at == eh / 2, "R7", mid_at, eh / 2);
        chk(nmid == 1, "R7", nmid, 1);
        chk(nrise == 1, "R6", nrise, 1);
    endtask

    task automatic start(input logic [15:0] cfg);
        en = 1'b0;
        clk_cfg = cfg;
        @(negedge clk);
        @(negedge clk);
        en = 1'b1;
        @(negedge clk);
        chk(scl_pull_low == 1'b1, "R9", int'(scl_pull_low), 1);
    endtask

    task automatic stop_and_check();
        en = 1'b0;
        for (int i = 0; i < 3; i++) begin
            @(negedge clk);
            chk(scl_pull_low == 1'b0, "R9", int'(scl_pull_low), 0);
            chk({rise_stb, mid_stb, fall_stb} == 3'b000, "R9",
                int'({rise_stb, mid_stb, fall_stb}), 0);
        end
    endtask

    initial begin
        #(200000 * 20);
        nfail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
        $finish;
    end

    initial begin
        rst_n = 1'b0; en = 1'b0; clk_cfg = 16'h0000; hold = 1'b0;
        for (int i = 0; i < 3; i++) begin
            @(negedge clk);
            chk(scl_pull_low == 1'b0, "R10", int'(scl_pull_low), 0);
        end
        rst_n = 1'b1;
        @(negedge clk);
        chk(scl_pull_low == 1'b0, "R10", int'(scl_pull_low), 0);
        chk({rise_stb, mid_stb, fall_stb} == 3'b000, "R10",
            int'({rise_stb, mid_stb, fall_stb}), 0);

        // Sweep of small settings, covering both minimums (R1, R2, R3).
        for (int h = 0; h < 10; h++) begin
            for (int l = 0; l < 10; l++) begin
                start({h[7:0], l[7:0]});
                run_low(l, 0, 1'b0, 16'h0, (l < 4) ? "R3" : "R2");
                run_high(h, 1'b0, 16'h0, (h < 2) ? "R3" : "R1");
                run_low(l, 0, 1'b0, 16'h0, (l < 4) ? "R3" : "R2");
                run_high(h, 1'b0, 16'h0, (h < 2) ? "R3" : "R1");
                stop_and_check();
            end
        end

        // Largest and asymmetric settings (R1, R2).
        start(16'hFFFF);
        run_low(255, 0, 1'b0, 16'h0, "R2");
        run_high(255, 1'b0, 16'h0, "R1");
        stop_and_check();
        start(16'h8041);
        run_low(8'h41, 0, 1'b0, 16'h0, "R2");
        run_high(8'h80, 1'b0, 16'h0, "R1");
        stop_and_check();

        // Settings rewritten in mid phase take effect at the next boundary (R5).
        start(16'h0506);
        run_low(6, 0, 1'b1, 16'h0307, "R5");
        run_high(3, 1'b1, 16'h0900, "R5");
        run_low(0, 0, 1'b0, 16'h0, "R5");
        run_high(9, 1'b0, 16'h0, "R5");
        stop_and_check();

        // Slave holding SCL low after release stretches the period (R4).
        start(16'h0305);
        run_low(5, 0, 1'b0, 16'h0, "R2");
        run_high(3, 1'b0, 16'h0, "R4");
        run_low(5, 1, 1'b0, 16'h0, "R4");
        run_high(3, 1'b0, 16'h0, "R4");
        run_low(5, 7, 1'b0, 16'h0, "R4");
        run_high(3, 1'b0, 16'h0, "R4");
        stop_and_check();

        // Disable in mid high phase, then a full low phase on re-enable (R9).
        start(16'h0606);
        run_low(6, 0, 1'b0, 16'h0, "R2");
        @(negedge clk);
        @(negedge clk);
        stop_and_check();
        en = 1'b1;
        @(negedge clk);
        chk(scl_pull_low == 1'b1, "R9", int'(scl_pull_low), 1);
        run_low(6, 0, 1'b0, 16'h0, "R9");
        run_high(6, 1'b0, 16'h0, "R1");

        // Disable in mid low phase (R9).
        @(negedge clk);
        @(negedge clk);
        stop_and_check();
        en = 1'b1;
        @(negedge clk);
        run_low(6, 0, 1'b0, 16'h0, "R9");
        run_high(6, 1'b0, 16'h0, "R1");
        stop_and_check();

        $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
        $finish;
    end
endmodule